// File: doc/BRIEF.md
# Four-Bank SDRAM Command Sequencer

This block sits between a request source and an SDRAM with four independent banks. A request names a bank, a row and a column and says whether it is a read or a write and whether the row should close by itself afterwards. The sequencer keeps the open/closed state and the open row of every bank. From that state it picks one command per clock: activate a closed bank, precharge a bank whose open row is wrong, or start the column access once the row is ready and the data bus is free. The command, its bank, its address and the auto-precharge flag are registered and appear on the outputs after the rising edge that decides them.

Each bank has its own timers for activate-to-column and precharge-to-activate spacing. A single bus timer holds the data bus for half the burst length, so one bank can be activated while another bank's burst still owns the bus. A free-running interval timer raises a refresh demand. While that demand is pending, new requests wait, open banks are closed, and one refresh goes out when every bank is idle. The requester holds its request until it sees the acknowledge pulse.

Top module: `bank_cmd_seq`

## Requirements
- R1: During and right after synchronous reset `cmd_code` is NOP (0) and `req_ack` is 0, and every bank counts as closed, so the first request to any bank produces an activate.
- R2: A request to a closed bank produces ACT (code 1) on the first edge after it is presented, with the requested bank on `cmd_bank` and the row on `cmd_addr`. The column command follows exactly `T_RCD` clocks later if the data bus is free by then.
- R3: A request whose row is already open in its bank produces the column command with no ACT or PRE. That command is RD (code 2) when `req_write` is 0 and WR (code 3) when it is 1, with the column on the low bits of `cmd_addr`.
- R4: A request to a bank with a different open row produces PRE (code 4) for that bank, then ACT exactly `T_RP` clocks later, then the column command `T_RCD` clocks after the ACT.
- R5: Consecutive column commands are spaced by at least the burst time of the earlier one, and exactly that when the later request is ready. The burst time is burst length / 2 clocks, with `bl_sel` 0, 1 and 2 or 3 selecting lengths 2, 4 and 8.
- R6: A column command issued with `req_autopre` set carries `cmd_ap` = 1. Its bank closes on its own when the burst ends, with no PRE command. The next request to that bank gets ACT (not PRE) exactly burst time + `T_RP` clocks after the column command.
- R7: An ACT to one bank may be issued while another bank's burst still holds the data bus.
- R8: Once the refresh interval expires, no ACT or column command for a request is issued. Open banks are precharged, lowest index first, one per clock. REF (code 5) is issued when all banks are closed and `T_RP` has elapsed since the last precharge. No command follows for `T_RFC` clocks.
- R9: `req_ack` is high for exactly the clock in which the request's column command is on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bl_sel | input | 2 | Burst length select: 0 = 2, 1 = 4, 2 or 3 = 8 |
| req_valid | input | 1 | A request is presented and held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_autopre | input | 1 | Close the row by itself after the burst |
| req_ack | output | 1 | Pulse: the request's column command is being issued |
| cmd_code | output | 3 | NOP 0, ACT 1, RD 2, WR 3, PRE 4, REF 5 |
| cmd_bank | output | 2 | Bank of the current command |
| cmd_addr | output | max(ROW_W,COL_W) | Row for ACT, column for RD/WR |
| cmd_ap | output | 1 | Auto-precharge flag on a column command |

## Verification
A bank whose open-row record is stale shows up on the very next request to that bank. The bench sees a missing PRE, a PRE before a row hit, or a column command issued with no ACT, and each shows in the first command cycle. A wrong per-bank or bus timer moves the ACT or the column command by one or more clocks, so the bench checks the exact cycle of every command relative to the cycle the request was presented. A broken auto-precharge or refresh path shows as an extra PRE, a missing REF, or an ACT inside the refresh quiet time, within a few clocks of the burst end or of the interval expiry.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int NUM_BANKS     = 4;
    localparam int BANK_W        = 2;
    localparam int MAX_BURST_CLK = 4;
    localparam int BUS_CNT_W     = $clog2(MAX_BURST_CLK + 1);

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } cmd_e;

    // Clocks a burst holds the data bus: burst length / 2.
    function automatic logic [BUS_CNT_W-1:0] burst_clocks(input logic [1:0] sel);
        case (sel)
            2'd0:    return BUS_CNT_W'(1);
            2'd1:    return BUS_CNT_W'(2);
            default: return BUS_CNT_W'(MAX_BURST_CLK);
        endcase
    endfunction

endpackage

// File: rtl/seq_bank_state.sv
module seq_bank_state #(
    parameter int ROW_W = 13,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             col_i,
    input  logic             ap_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             act_ok_o,
    output logic             pre_ok_o,
    output logic             ap_pend_o
);
    localparam int RCD_W = $clog2(T_RCD + 1);
    localparam int RP_W  = $clog2(T_RP + 1);

    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [RCD_W-1:0] act_cnt_q;
    logic [RP_W-1:0]  pre_cnt_q;
    logic             ap_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q    <= 1'b0;
            row_q     <= '0;
            act_cnt_q <= '0;
            pre_cnt_q <= '0;
            ap_pend_q <= 1'b0;
        end else begin
            if (act_i) begin
                open_q    <= 1'b1;
                row_q     <= row_i;
                act_cnt_q <= RCD_W'(T_RCD);
            end else if (act_cnt_q != '0) begin
                act_cnt_q <= act_cnt_q - 1'b1;
            end

            if (pre_i || close_i) begin
                open_q    <= 1'b0;
                pre_cnt_q <= RP_W'(T_RP);
            end else if (pre_cnt_q != '0) begin
                pre_cnt_q <= pre_cnt_q - 1'b1;
            end

            if (close_i)
                ap_pend_q <= 1'b0;
            else if (col_i && ap_i)
                ap_pend_q <= 1'b1;
        end
    end

    assign open_o    = open_q;
    assign row_o     = row_q;
    assign act_ok_o  = (act_cnt_q <= RCD_W'(1));
    assign pre_ok_o  = (pre_cnt_q <= RP_W'(1));
    assign ap_pend_o = ap_pend_q;

    AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (rst) act_i |-> !open_q); // R2
    AST_COL_AFTER_RCD: assert property (@(posedge clk) disable iff (rst) col_i |-> (open_q && act_cnt_q <= RCD_W'(1))); // R3
    AST_ACT_AFTER_RP: assert property (@(posedge clk) disable iff (rst) act_i |-> (pre_cnt_q <= RP_W'(1))); // R4
    AST_AP_CLOSE_OWN: assert property (@(posedge clk) disable iff (rst) close_i |-> (ap_pend_q && open_q)); // R6

endmodule

// File: rtl/seq_bus_timer.sv
module seq_bus_timer import seq_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              col_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [1:0]        bl_sel_i,
    output logic              free_o,
    output logic              burst_end_o,
    output logic [BANK_W-1:0] bank_o
);
    logic [BUS_CNT_W-1:0] cnt_q;
    logic [BANK_W-1:0]    bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            bank_q <= '0;
        end else if (col_i) begin
            cnt_q  <= burst_clocks(bl_sel_i);
            bank_q <= bank_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign free_o      = (cnt_q <= BUS_CNT_W'(1));
    assign burst_end_o = (cnt_q == BUS_CNT_W'(1));
    assign bank_o      = bank_q;

    AST_COL_BUS_GAP: assert property (@(posedge clk) disable iff (rst) col_i |-> (cnt_q <= BUS_CNT_W'(1))); // R5

endmodule

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
    parameter int REF_INTERVAL = 1560,
    parameter int T_RFC        = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_i,
    output logic due_o,
    output logic quiet_done_o
);
    localparam int INT_W = $clog2(REF_INTERVAL + 1);
    localparam int RFC_W = $clog2(T_RFC + 1);

    logic [INT_W-1:0] int_cnt_q;
    logic [RFC_W-1:0] rfc_cnt_q;
    logic             due_q;
    logic             expire;

    assign expire = (int_cnt_q == INT_W'(REF_INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            int_cnt_q <= '0;
            rfc_cnt_q <= '0;
            due_q     <= 1'b0;
        end else begin
            int_cnt_q <= expire ? '0 : int_cnt_q + 1'b1;

            if (expire)
                due_q <= 1'b1;
            else if (ref_i)
                due_q <= 1'b0;

            if (ref_i)
                rfc_cnt_q <= RFC_W'(T_RFC);
            else if (rfc_cnt_q != '0)
                rfc_cnt_q <= rfc_cnt_q - 1'b1;
        end
    end

    assign due_o        = due_q;
    assign quiet_done_o = (rfc_cnt_q <= RFC_W'(1));

    AST_REF_ONLY_DUE: assert property (@(posedge clk) disable iff (rst) ref_i |-> (due_q && rfc_cnt_q <= RFC_W'(1))); // R8

endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq import seq_pkg::*; #(
    parameter int ROW_W        = 13,
    parameter int COL_W        = 10,
    parameter int T_RCD        = 3,
    parameter int T_RP         = 3,
    parameter int T_RFC        = 8,
    parameter int REF_INTERVAL = 1560,
    localparam int ADDR_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bl_sel,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_autopre,
    output logic              req_ack,
    output logic [2:0]        cmd_code,
    output logic [1:0]        cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ap
);
    logic [NUM_BANKS-1:0] open_v, act_ok_v, pre_ok_v, ap_pend_v, close_v, bank_busy;
    logic [ROW_W-1:0]     row_v [NUM_BANKS];

    logic              bus_free, burst_end;
    logic [BANK_W-1:0] bus_bank;
    logic              ref_due, rfc_ok;

    cmd_e              nxt;
    logic [BANK_W-1:0] nxt_bank;
    logic [ADDR_W-1:0] nxt_addr;
    logic              nxt_ap;
    logic              do_act, do_pre, do_col, do_ref;

    cmd_e              cmd_q;

    // Pick one command per clock: refresh work first, then the request.
    always_comb begin
        nxt      = CMD_NOP;
        nxt_bank = '0;
        nxt_addr = '0;
        nxt_ap   = 1'b0;
        if (rfc_ok) begin
            if (ref_due) begin
                if (open_v == '0 && (&pre_ok_v)) begin
                    nxt = CMD_REF;
                end else begin
                    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
                        if (open_v[b] && !ap_pend_v[b] && !bank_busy[b]) begin
                            nxt      = CMD_PRE;
                            nxt_bank = BANK_W'(b);
                        end
                    end
                end
            end else if (req_valid && !ap_pend_v[req_bank]) begin
                nxt_bank = req_bank;
                if (!open_v[req_bank]) begin
                    if (pre_ok_v[req_bank]) begin
                        nxt      = CMD_ACT;
                        nxt_addr = ADDR_W'(req_row);
                    end
                end else if (row_v[req_bank] != req_row) begin
                    if (!bank_busy[req_bank])
                        nxt = CMD_PRE;
                end else if (act_ok_v[req_bank] && bus_free) begin
                    nxt      = req_write ? CMD_WR : CMD_RD;
                    nxt_addr = ADDR_W'(req_col);
                    nxt_ap   = req_autopre;
                end
            end
        end
    end

    assign do_act = (nxt == CMD_ACT);
    assign do_pre = (nxt == CMD_PRE);
    assign do_col = (nxt == CMD_RD) || (nxt == CMD_WR);
    assign do_ref = (nxt == CMD_REF);

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign bank_busy[b] = !bus_free && (bus_bank == BANK_W'(b));
            assign close_v[b]   = burst_end && (bus_bank == BANK_W'(b)) && ap_pend_v[b];

            seq_bank_state #(
                .ROW_W (ROW_W),
                .T_RCD (T_RCD),
                .T_RP  (T_RP)
            ) u_bank (
                .clk       (clk),
                .rst       (rst),
                .act_i     (do_act && nxt_bank == BANK_W'(b)),
                .pre_i     (do_pre && nxt_bank == BANK_W'(b)),
                .col_i     (do_col && nxt_bank == BANK_W'(b)),
                .ap_i      (nxt_ap),
                .close_i   (close_v[b]),
                .row_i     (req_row),
                .open_o    (open_v[b]),
                .row_o     (row_v[b]),
                .act_ok_o  (act_ok_v[b]),
                .pre_ok_o  (pre_ok_v[b]),
                .ap_pend_o (ap_pend_v[b])
            );
        end
    endgenerate

    seq_bus_timer u_bus (
        .clk         (clk),
        .rst         (rst),
        .col_i       (do_col),
        .bank_i      (nxt_bank),
        .bl_sel_i    (bl_sel),
        .free_o      (bus_free),
        .burst_end_o (burst_end),
        .bank_o      (bus_bank)
    );

    seq_refresh_timer #(
        .REF_INTERVAL (REF_INTERVAL),
        .T_RFC        (T_RFC)
    ) u_ref (
        .clk          (clk),
        .rst          (rst),
        .ref_i        (do_ref),
        .due_o        (ref_due),
        .quiet_done_o (rfc_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= CMD_NOP;
            cmd_bank <= '0;
            cmd_addr <= '0;
            cmd_ap   <= 1'b0;
            req_ack  <= 1'b0;
        end else begin
            cmd_q    <= nxt;
            cmd_bank <= nxt_bank;
            cmd_addr <= nxt_addr;
            cmd_ap   <= nxt_ap;
            req_ack  <= do_col;
        end
    end

    assign cmd_code = cmd_q;

    AST_ACK_WITH_COL: assert property (@(posedge clk) disable iff (rst) req_ack |-> (cmd_q == CMD_RD || cmd_q == CMD_WR)); // R9
    AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (rst) do_ref |-> (open_v == '0 && ap_pend_v == '0)); // R8
    AST_NO_REQ_WHILE_DUE: assert property (@(posedge clk) disable iff (rst) (do_act || do_col) |-> !ref_due); // R8
    AST_AP_FLAG_ON_COL: assert property (@(posedge clk) disable iff (rst) cmd_ap |-> (cmd_q == CMD_RD || cmd_q == CMD_WR)); // R6

endmodule

// File: tb/sim_bank_cmd_seq.sv
module sim_bank_cmd_seq;
    localparam int ROW_W   = 12;
    localparam int COL_W   = 9;
    localparam int ADDR_W  = 12;
    localparam int T_RCD   = 2;
    localparam int T_RP    = 3;
    localparam int T_RFC   = 7;
    localparam int REF_INT = 600;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        bl_sel = 2'd0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [1:0]        req_bank = 2'd0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic              req_autopre = 1'b0;
    logic              req_ack;
    logic [2:0]        cmd_code;
    logic [1:0]        cmd_bank;
    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_ap;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    int lg_n = 0;
    int lg_code [64];
    int lg_bank [64];
    int lg_addr [64];
    int lg_ap   [64];
    int lg_cyc  [64];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    bank_cmd_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP),
        .T_RFC(T_RFC), .REF_INTERVAL(REF_INT)
    ) u0 (
        .clk(clk), .rst(rst), .bl_sel(bl_sel), .req_valid(req_valid),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_autopre(req_autopre), .req_ack(req_ack),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap)
    );

    // Command log, sampled at the falling edge.
    always @(negedge clk) begin
        if (!rst && cmd_code != 3'd0 && lg_n < 64) begin
            lg_code[lg_n] = int'(cmd_code);
            lg_bank[lg_n] = int'(cmd_bank);
            lg_addr[lg_n] = int'(cmd_addr);
            lg_ap[lg_n]   = int'(cmd_ap);
            lg_cyc[lg_n]  = cyc;
            lg_n = lg_n + 1;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
        $finish;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Present a request now (just after a falling edge) and hold it until acknowledged.
    task automatic run_req(input logic wr, input logic [1:0] bk, input int row, input int col,
                           input logic ap, output int base, output int start, output int ackc);
        base = lg_n;
        start = cyc;
        req_valid = 1'b1; req_write = wr; req_bank = bk;
        req_row = ROW_W'(row); req_col = COL_W'(col); req_autopre = ap;
        ackc = -1;
        for (int i = 0; i < 300; i++) begin
            tick();
            if (req_ack) begin
                ackc = cyc;
                break;
            end
        end
        req_valid = 1'b0;
        if (ackc < 0) chk("R9 ack timeout", 0, 1);
    endtask

    task automatic test_reset();
        chk("R1 cmd in reset", int'(cmd_code), 0);
        chk("R1 ack in reset", int'(req_ack), 0);
        rst = 1'b0;
        tick();
        chk("R1 cmd after reset", int'(cmd_code), 0);
        chk("R1 ack after reset", int'(req_ack), 0);
    endtask

    task automatic test_closed_bank();
        int b, s, a;
        bl_sel = 2'd0;
        run_req(1'b0, 2'd0, 5, 8, 1'b0, b, s, a);
        chk("R1 R2 first cmd is ACT", lg_code[b], 1);
        chk("R2 ACT bank", lg_bank[b], 0);
        chk("R2 ACT row", lg_addr[b], 5);
        chk("R2 ACT cycle", lg_cyc[b], s + 1);
        chk("R3 RD code", lg_code[b+1], 2);
        chk("R3 RD column", lg_addr[b+1], 8);
        chk("R2 RD after T_RCD", lg_cyc[b+1], s + 1 + T_RCD);
        chk("R9 ack with column cmd", a, lg_cyc[b+1]);
        tick();
        chk("R9 ack one clock", int'(req_ack), 0);
    endtask

    task automatic test_row_hit();
        int b, s, a;
        run_req(1'b1, 2'd0, 5, 16, 1'b0, b, s, a);
        chk("R3 hit single cmd", lg_n - b, 1);
        chk("R3 WR code", lg_code[b], 3);
        chk("R3 WR column", lg_addr[b], 16);
        chk("R3 WR cycle", lg_cyc[b], s + 1);
    endtask

    task automatic test_row_miss();
        int b, s, a;
        run_req(1'b0, 2'd0, 9, 2, 1'b0, b, s, a);
        chk("R4 miss cmd count", lg_n - b, 3);
        chk("R4 PRE first", lg_code[b], 4);
        chk("R4 PRE cycle", lg_cyc[b], s + 1);
        chk("R4 ACT second", lg_code[b+1], 1);
        chk("R4 ACT row", lg_addr[b+1], 9);
        chk("R4 ACT after T_RP", lg_cyc[b+1], s + 1 + T_RP);
        chk("R4 RD after T_RCD", lg_cyc[b+2], s + 1 + T_RP + T_RCD);
    endtask

    task automatic test_burst_gap();
        int b, s, a1, a2, a3, a4;
        bl_sel = 2'd1;
        run_req(1'b0, 2'd0, 9, 3, 1'b0, b, s, a1);
        run_req(1'b0, 2'd0, 9, 4, 1'b0, b, s, a2);
        chk("R5 gap for length 4", a2 - a1, 2);
        bl_sel = 2'd2;
        run_req(1'b0, 2'd0, 9, 5, 1'b0, b, s, a3);
        run_req(1'b1, 2'd0, 9, 6, 1'b0, b, s, a4);
        chk("R5 gap for length 8", a4 - a3, 4);
    endtask

    task automatic test_auto_pre();
        int b, s, a, b2, s2, a2;
        bl_sel = 2'd2;
        run_req(1'b0, 2'd1, 3, 4, 1'b1, b, s, a);
        chk("R6 ap flag on RD", lg_ap[b+1], 1);
        chk("R6 RD code", lg_code[b+1], 2);
        run_req(1'b0, 2'd1, 3, 5, 1'b1, b2, s2, a2);
        chk("R6 reopen is ACT not PRE", lg_code[b2], 1);
        chk("R6 reopen cycle", lg_cyc[b2], a + 4 + T_RP);
    endtask

    task automatic test_overlap();
        int b, s, a0, b2, s2, a2;
        bl_sel = 2'd2;
        run_req(1'b0, 2'd0, 9, 6, 1'b0, b, s, a0);
        run_req(1'b0, 2'd2, 7, 1, 1'b0, b2, s2, a2);
        chk("R7 ACT during busy bus", lg_code[b2], 1);
        chk("R7 ACT cycle", lg_cyc[b2], a0 + 1);
        chk("R7 bank 2 column waits for bus", a2, a0 + 4);
    endtask

    task automatic test_refresh();
        int b, s, a, ref_c, b2;
        b = lg_n;
        ref_c = -1;
        for (int i = 0; i < 2000; i++) begin
            tick();
            if (lg_n > b && lg_code[lg_n-1] == 5) begin
                ref_c = cyc;
                break;
            end
        end
        chk("R8 REF seen", (ref_c >= 0) ? 1 : 0, 1);
        chk("R8 cmd count before REF", lg_n - b, 3);
        chk("R8 PRE bank 0 first", lg_code[b] * 10 + lg_bank[b], 40);
        chk("R8 PRE bank 2 second", lg_code[b+1] * 10 + lg_bank[b+1], 42);
        chk("R8 PRE back to back", lg_cyc[b+1], lg_cyc[b] + 1);
        chk("R8 REF after T_RP", ref_c, lg_cyc[b+1] + T_RP);
        run_req(1'b0, 2'd0, 1, 0, 1'b0, b2, s, a);
        chk("R8 ACT after quiet time", lg_cyc[b2], ref_c + T_RFC);
        chk("R8 ACT code after REF", lg_code[b2], 1);
    endtask

    initial begin
        repeat (4) tick();
        test_reset();
        test_closed_bank();
        test_row_hit();
        test_row_miss();
        test_burst_gap();
        test_auto_pre();
        test_overlap();
        test_refresh();
        repeat (4) tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule